// File: doc/BRIEF.md
# Converter Scan Sequencer with Result Queue

This block is the digital control for the internally clocked scan path of a multichannel converter. A host talks to it over a four-wire serial link (chip select, serial clock, data in, data out). A conversion command byte names the highest channel to visit, picks between a sweep from channel 0 and a single channel, and can also ask for a temperature reading. The sequencer then switches the converter model on and waits a fixed warm-up time. It runs one conversion per requested item and writes each result into an on-chip queue. When the scan is over it switches the converter off and drives an active-low done flag.

The analog conversion is replaced by a deterministic stub, so every result can be predicted. The host drains the queue by sending a read command and then clocking out 16-bit frames, one frame per stored result. An 8-bit side register can be written and read back over the same link while a scan is running. This lets the host check that traffic for other registers is accepted during a scan.

Top module: `adc_scan_seq`

## Requirements
- R1: A command byte with bit 7 set starts a scan when the sequencer is idle: adc_pwr goes high and eoc_n stays high while the scan runs. Bit 6 asks for temperature, bit 5 selects single-channel mode, and bits 2:0 give channel N. Bits are sent MSB first, sampled on the rising serial clock edge while cs_n is low.
- R2: In sweep mode (bit 5 clear) the results of channels 0 through N are queued in ascending order. In single mode only channel N is queued. The stub result for channel c is 37 + 100*c, right-justified in a 16-bit word.
- R3: When temperature is requested, the 12-bit temperature code (default 0xC35) is queued ahead of every channel result, right-justified in 16 bits.
- R4: eoc_n falls and adc_pwr falls once the scan is complete, PWR_CYC + n*CONV_CYC clock cycles after the command byte, where n is the number of queued results. At that point the queue already holds every result.
- R5: eoc_n stays low until the next falling edge of cs_n, and then returns high.
- R6: A conversion command that arrives while a scan is running is ignored: the running scan's results are the only ones queued.
- R7: Byte 0x40 followed by a data byte writes the side register. Byte 0x20 followed by 16-bit frames reads it back as 0x00dd. Both are accepted during a scan.
- R8: Byte 0x00 followed by 16-bit frames (MSB first, bit valid before each rising edge) pops one queued result per frame. A frame taken from an empty queue reads as zero and sets underflow, which holds until the next falling edge of cs_n.
- R9: Starting a scan discards any results left in the queue from an earlier scan.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the serial clock is oversampled on it |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock, idles high |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| eoc_n | output | 1 | Active-low scan-complete flag |
| adc_pwr | output | 1 | Converter model powered |
| underflow | output | 1 | Read from empty queue since last chip select |

## Verification
The command byte is taken at the rising edge of its eighth serial clock. A scan of n results finishes PWR_CYC + n*CONV_CYC system cycles later, give or take two cycles for the edge detector and the start register. The bench therefore checks that eoc_n is still high four cycles before that point and has fallen four cycles after it, and checks adc_pwr at the midpoint. Read data is due one system cycle after the serial falling edge that opens each bit slot, and the bench samples it two cycles into the low phase. Underflow and eoc_n changes are checked a few cycles after the frame or chip-select edge that causes them.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    localparam int WORD_W = 16;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_WAKE,
        SQ_CONV
    } seq_state_t;

    typedef enum logic [1:0] {
        PH_CMD,
        PH_WDATA,
        PH_RDATA,
        PH_SKIP
    } ser_phase_t;

    typedef struct packed {
        logic       temp;
        logic       single;
        logic [2:0] chan;
    } scan_req_t;

    function automatic scan_req_t decode_scan(input logic [7:0] b);
        scan_req_t r;
        r.temp   = b[6];
        r.single = b[5];
        r.chan   = b[2:0];
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] stub_chan(input logic [2:0] ch);
        return WORD_W'(37) + WORD_W'(ch) * WORD_W'(100);
    endfunction

    function automatic logic [WORD_W-1:0] stub_temp(input logic [11:0] code);
        return {4'b0000, code};
    endfunction

endpackage

// File: rtl/adc_fifo.sv
module adc_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [AW:0]   count;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == (AW+1)'(DEPTH));
    assign rdata   = mem[rptr];
    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= wptr + 1'b1;
            if (do_pop)  rptr <= rptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R9: flushing at scan start keeps a full scan within the queue
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);

    assert_count_range_R8: assert property (@(posedge clk) disable iff (rst)
        count <= (AW+1)'(DEPTH));

endmodule

// File: rtl/adc_ser_port.sv
module adc_ser_port
    import adc_scan_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              mosi,
    output logic              miso,
    output logic              underflow,
    output logic              cs_fall,
    output logic              scan_go,
    output scan_req_t         scan_req,
    output logic              fifo_pop,
    input  logic              fifo_empty,
    input  logic [WORD_W-1:0] fifo_rdata
);
    logic              sclk_q, cs_q;
    logic              s_rise, s_fall;
    ser_phase_t        phase;
    logic [3:0]        bit_cnt;
    logic [7:0]        in_sr, in_next;
    logic [WORD_W-1:0] out_sr;
    logic              load_pend, aux_sel;
    logic [7:0]        aux_q;
    logic              udf_q, go_q;
    scan_req_t         req_q;
    logic              do_load;

    assign s_rise   = ~cs_n & sclk & ~sclk_q;
    assign s_fall   = ~cs_n & ~sclk & sclk_q;
    assign cs_fall  = cs_q & ~cs_n;
    assign in_next  = {in_sr[6:0], mosi};
    assign do_load  = s_fall & load_pend;
    assign fifo_pop = do_load & ~aux_sel & ~fifo_empty;

    assign miso      = out_sr[WORD_W-1];
    assign underflow = udf_q;
    assign scan_go   = go_q;
    assign scan_req  = req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q    <= 1'b1;
            cs_q      <= 1'b1;
            phase     <= PH_CMD;
            bit_cnt   <= '0;
            in_sr     <= '0;
            out_sr    <= '0;
            load_pend <= 1'b0;
            aux_sel   <= 1'b0;
            aux_q     <= '0;
            udf_q     <= 1'b0;
            go_q      <= 1'b0;
            req_q     <= '0;
        end else begin
            sclk_q <= sclk;
            cs_q   <= cs_n;
            go_q   <= 1'b0;
            if (cs_fall) udf_q <= 1'b0;
            if (cs_n) begin
                phase     <= PH_CMD;
                bit_cnt   <= '0;
                load_pend <= 1'b0;
            end else begin
                if (s_rise) begin
                    in_sr   <= in_next;
                    bit_cnt <= bit_cnt + 1'b1;
                    case (phase)
                        PH_CMD: begin
                            if (bit_cnt[2:0] == 3'd7) begin
                                bit_cnt <= '0;
                                if (in_next[7]) begin
                                    go_q  <= 1'b1;
                                    req_q <= decode_scan(in_next);
                                    phase <= PH_SKIP;
                                end else if (in_next[6]) begin
                                    phase <= PH_WDATA;
                                end else begin
                                    phase     <= PH_RDATA;
                                    aux_sel   <= in_next[5];
                                    load_pend <= 1'b1;
                                end
                            end
                        end
                        PH_WDATA: begin
                            if (bit_cnt[2:0] == 3'd7) begin
                                aux_q   <= in_next;
                                bit_cnt <= '0;
                                phase   <= PH_SKIP;
                            end
                        end
                        PH_RDATA: begin
                            if (bit_cnt == 4'd15) load_pend <= 1'b1;
                            else                  out_sr    <= out_sr << 1;
                        end
                        default: ;
                    endcase
                end
                if (do_load) begin
                    load_pend <= 1'b0;
                    if (aux_sel)         out_sr <= {8'h00, aux_q};
                    else if (fifo_empty) out_sr <= '0;
                    else                 out_sr <= fifo_rdata;
                    if (!aux_sel && fifo_empty) udf_q <= 1'b1;
                end
            end
        end
    end

    // R8: an empty-queue frame raises underflow on the next cycle
    assert_udf_on_empty_R8: assert property (@(posedge clk) disable iff (rst)
        (do_load && !aux_sel && fifo_empty) |=> underflow);

    // R1: a command is a single-cycle pulse
    assert_go_pulse_R1: assert property (@(posedge clk) disable iff (rst)
        scan_go |=> !scan_go);

endmodule

// File: rtl/adc_seq.sv
module adc_seq
    import adc_scan_pkg::*;
#(
    parameter int          NUM_CH    = 8,
    parameter int          PWR_CYC   = 16,
    parameter int          CONV_CYC  = 24,
    parameter logic [11:0] TEMP_CODE = 12'hC35
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scan_go,
    input  scan_req_t         scan_req,
    input  logic              cs_fall,
    output logic              push,
    output logic [WORD_W-1:0] push_data,
    output logic              flush,
    output logic              pwr,
    output logic              eoc_n
);
    localparam int         CNT_MAX = (PWR_CYC > CONV_CYC) ? PWR_CYC : CONV_CYC;
    localparam int         CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [2:0] MAX_CH  = 3'(NUM_CH - 1);

    seq_state_t        st;
    logic [CNT_W-1:0]  cnt;
    logic              temp_pend, fin_q, eoc_q;
    logic [2:0]        cur_ch, end_ch, req_end;
    logic              push_q, flush_q;
    logic [WORD_W-1:0] data_q;

    assign req_end   = (scan_req.chan > MAX_CH) ? MAX_CH : scan_req.chan;
    assign push      = push_q;
    assign push_data = data_q;
    assign flush     = flush_q;
    assign pwr       = (st != SQ_IDLE);
    assign eoc_n     = ~eoc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= SQ_IDLE;
            cnt       <= '0;
            temp_pend <= 1'b0;
            cur_ch    <= '0;
            end_ch    <= '0;
            fin_q     <= 1'b0;
            eoc_q     <= 1'b0;
            push_q    <= 1'b0;
            flush_q   <= 1'b0;
            data_q    <= '0;
        end else begin
            push_q  <= 1'b0;
            flush_q <= 1'b0;
            fin_q   <= 1'b0;
            if (cs_fall) eoc_q <= 1'b0;
            if (fin_q)   eoc_q <= 1'b1;
            case (st)
                SQ_IDLE: begin
                    if (scan_go) begin
                        st        <= SQ_WAKE;
                        cnt       <= '0;
                        temp_pend <= scan_req.temp;
                        end_ch    <= req_end;
                        cur_ch    <= scan_req.single ? req_end : 3'd0;
                        flush_q   <= 1'b1;
                    end
                end
                SQ_WAKE: begin
                    if (cnt == CNT_W'(PWR_CYC - 1)) begin
                        st  <= SQ_CONV;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SQ_CONV: begin
                    if (cnt == CNT_W'(CONV_CYC - 1)) begin
                        cnt    <= '0;
                        push_q <= 1'b1;
                        if (temp_pend) begin
                            temp_pend <= 1'b0;
                            data_q    <= stub_temp(TEMP_CODE);
                        end else begin
                            data_q <= stub_chan(cur_ch);
                            if (cur_ch == end_ch) begin
                                st    <= SQ_IDLE;
                                fin_q <= 1'b1;
                            end else begin
                                cur_ch <= cur_ch + 1'b1;
                            end
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    // R1: the converter is never powered while the done flag is low
    assert_pwr_eoc_R1: assert property (@(posedge clk) disable iff (rst)
        pwr |-> eoc_n);

    // R5: the done flag only returns high on a chip-select fall
    assert_eoc_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!eoc_n && !cs_fall) |=> !eoc_n);

    // R6: a command during a scan leaves the scan's range untouched
    assert_busy_ignore_R6: assert property (@(posedge clk) disable iff (rst)
        (scan_go && st != SQ_IDLE) |=> $stable(end_ch));

    // R3: temperature is always pushed before any channel result
    assert_temp_first_R3: assert property (@(posedge clk) disable iff (rst)
        (st == SQ_CONV && temp_pend) |-> (cur_ch == 3'd0 || cur_ch == end_ch));

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_scan_pkg::*;
#(
    parameter int          NUM_CH     = 8,
    parameter int          FIFO_DEPTH = 16,
    parameter int          PWR_CYC    = 16,
    parameter int          CONV_CYC   = 24,
    parameter logic [11:0] TEMP_CODE  = 12'hC35
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic sclk,
    input  logic mosi,
    output logic miso,
    output logic eoc_n,
    output logic adc_pwr,
    output logic underflow
);
    logic              cs_fall, scan_go;
    scan_req_t         scan_req;
    logic              fifo_pop, fifo_empty, fifo_full;
    logic [WORD_W-1:0] fifo_rdata;
    logic              push, flush;
    logic [WORD_W-1:0] push_data;

    adc_ser_port u_ser (
        .clk        (clk),
        .rst        (rst),
        .cs_n       (cs_n),
        .sclk       (sclk),
        .mosi       (mosi),
        .miso       (miso),
        .underflow  (underflow),
        .cs_fall    (cs_fall),
        .scan_go    (scan_go),
        .scan_req   (scan_req),
        .fifo_pop   (fifo_pop),
        .fifo_empty (fifo_empty),
        .fifo_rdata (fifo_rdata)
    );

    adc_seq #(
        .NUM_CH    (NUM_CH),
        .PWR_CYC   (PWR_CYC),
        .CONV_CYC  (CONV_CYC),
        .TEMP_CODE (TEMP_CODE)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .scan_go   (scan_go),
        .scan_req  (scan_req),
        .cs_fall   (cs_fall),
        .push      (push),
        .push_data (push_data),
        .flush     (flush),
        .pwr       (adc_pwr),
        .eoc_n     (eoc_n)
    );

    adc_fifo #(
        .DEPTH (FIFO_DEPTH),
        .W     (WORD_W)
    ) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .flush (flush),
        .push  (push),
        .wdata (push_data),
        .pop   (fifo_pop),
        .rdata (fifo_rdata),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    // R4: results are in the queue by the time the done flag falls
    assert_eoc_data_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(eoc_n) |-> !fifo_empty);

    // R9: a flush never coincides with a full queue being pushed
    assert_flush_push_R9: assert property (@(posedge clk) disable iff (rst)
        flush |-> !push);

endmodule

// File: tb/adc_scan_seq_bench.sv
module adc_scan_seq_bench;
    localparam int          PWR   = 16;
    localparam int          CONV  = 24;
    localparam logic [15:0] TEMPW = 16'h0C35;
    localparam int          NV    = 6;
    localparam logic [7:0]  VEC_CMD [NV] = '{8'h87, 8'hC3, 8'hA5, 8'hE2, 8'h80, 8'hC7};
    localparam int          VEC_N   [NV] = '{8, 5, 1, 2, 1, 9};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1;
    logic sclk = 1'b1;
    logic mosi = 1'b0;
    logic miso, eoc_n, adc_pwr, underflow;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    adc_scan_seq #(
        .PWR_CYC  (PWR),
        .CONV_CYC (CONV)
    ) u_adc_scan_seq (
        .clk       (clk),
        .rst       (rst),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .mosi      (mosi),
        .miso      (miso),
        .eoc_n     (eoc_n),
        .adc_pwr   (adc_pwr),
        .underflow (underflow)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] chan_val(input int c);
        return 16'(37 + 100 * c);
    endfunction

    function automatic logic [15:0] exp_word(input logic [7:0] cmd, input int k);
        int t;
        t = cmd[6] ? 1 : 0;
        if (cmd[6] && k == 0) return TEMPW;
        if (cmd[5]) return chan_val(int'(cmd[2:0]));
        return chan_val(k - t);
    endfunction

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer_bit(input logic b, output logic r);
        @(negedge clk);
        sclk = 1'b0;
        mosi = b;
        wait_cyc(2);
        r = miso;
        sclk = 1'b1;
        wait_cyc(1);
    endtask

    task automatic xfer_byte(input logic [7:0] b);
        logic r;
        for (int i = 7; i >= 0; i--) xfer_bit(b[i], r);
    endtask

    task automatic xfer_word(output logic [15:0] w);
        logic r;
        for (int i = 15; i >= 0; i--) begin
            xfer_bit(1'b0, r);
            w[i] = r;
        end
    endtask

    task automatic send_cmd(input logic [7:0] b);
        @(negedge clk);
        cs_n = 1'b0;
        xfer_byte(b);
        cs_n = 1'b1;
    endtask

    task automatic read_check(input logic [7:0] cmd, input int n, input string tag);
        logic [15:0] w;
        @(negedge clk);
        cs_n = 1'b0;
        xfer_byte(8'h00);
        for (int k = 0; k < n; k++) begin
            xfer_word(w);
            check(tag, 32'(w), 32'(exp_word(cmd, k)));
        end
        cs_n = 1'b1;
    endtask

    task automatic wait_eoc(input int limit);
        int c;
        c = 0;
        while (eoc_n !== 1'b0 && c < limit) begin
            @(negedge clk);
            c++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] w;
        int t;
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(2);
        check("R1 reset eoc_n", 32'(eoc_n), 32'd1);
        check("R1 reset adc_pwr", 32'(adc_pwr), 32'd0);
        check("R8 reset underflow", 32'(underflow), 32'd0);
        check("R8 reset miso", 32'(miso), 32'd0);

        // vector table: R1 R2 R3 R4 R5
        for (int v = 0; v < NV; v++) begin
            t = PWR + VEC_N[v] * CONV;
            send_cmd(VEC_CMD[v]);
            wait_cyc(t / 2);
            check("R1 pwr mid-scan", 32'(adc_pwr), 32'd1);
            check("R1 eoc_n high mid-scan", 32'(eoc_n), 32'd1);
            wait_cyc(t - 4 - t / 2);
            check("R4 eoc_n before done", 32'(eoc_n), 32'd1);
            wait_cyc(8);
            check("R4 eoc_n low at done", 32'(eoc_n), 32'd0);
            check("R4 pwr off at done", 32'(adc_pwr), 32'd0);
            wait_cyc(30);
            check("R5 eoc_n held low", 32'(eoc_n), 32'd0);
            read_check(VEC_CMD[v], VEC_N[v], "R2 R3 result word");
            wait_cyc(2);
            check("R5 eoc_n cleared by cs fall", 32'(eoc_n), 32'd1);
            check("R8 no underflow on full read", 32'(underflow), 32'd0);
        end

        // R6 R7: commands and side-register write during a scan
        send_cmd(8'hC7);
        wait_cyc(4);
        @(negedge clk);
        cs_n = 1'b0;
        xfer_byte(8'h40);
        xfer_byte(8'h5A);
        cs_n = 1'b1;
        send_cmd(8'hA5);
        check("R6 still scanning", 32'(adc_pwr), 32'd1);
        wait_eoc(600);
        check("R6 scan completed", 32'(eoc_n), 32'd0);
        read_check(8'hC7, 9, "R6 ignored command");
        @(negedge clk);
        cs_n = 1'b0;
        xfer_byte(8'h20);
        xfer_word(w);
        cs_n = 1'b1;
        check("R7 side register readback", 32'(w), 32'h005A);

        // R8: empty queue read
        @(negedge clk);
        cs_n = 1'b0;
        xfer_byte(8'h00);
        xfer_word(w);
        cs_n = 1'b1;
        wait_cyc(2);
        check("R8 empty read value", 32'(w), 32'd0);
        check("R8 underflow set", 32'(underflow), 32'd1);
        wait_cyc(10);
        check("R8 underflow held", 32'(underflow), 32'd1);
        @(negedge clk);
        cs_n = 1'b0;
        wait_cyc(3);
        check("R8 underflow cleared", 32'(underflow), 32'd0);
        cs_n = 1'b1;

        // R9: stale results discarded by new scan
        send_cmd(8'h82);
        wait_cyc(PWR + 3 * CONV + 4);
        check("R9 first scan done", 32'(eoc_n), 32'd0);
        send_cmd(8'hA5);
        wait_cyc(PWR + CONV + 4);
        check("R9 second scan done", 32'(eoc_n), 32'd0);
        @(negedge clk);
        cs_n = 1'b0;
        xfer_byte(8'h00);
        xfer_word(w);
        check("R9 only new result", 32'(w), 32'(chan_val(5)));
        xfer_word(w);
        cs_n = 1'b1;
        wait_cyc(2);
        check("R9 stale word gone", 32'(w), 32'd0);
        check("R9 underflow after one", 32'(underflow), 32'd1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule